// File: doc/BRIEF.md
# Dual-Memory Host Bus Controller

This block sits between a host request port and a package holding a 16-bit word-wide flash and an 8-bit byte-wide SRAM. The two memories share one address bus and one data bus. The block turns each host request into chip-enable, output-enable and write-enable pulses for one memory at a time. It never lets both memories own the bus together. Every access opens with a cycle in which all enables are high, so one memory's enable cannot go low in the cycle right after the other's.

The block also drives the flash reset/power-down line. It holds that line low for a programmable time after the supply-good input rises, and it pulls the line low at once when the supply goes away. On a power-down request it takes the flash into deep power-down as soon as the bus is idle, and it keeps the flash there for a minimum time. After each release it counts separate read and write recovery windows. Flash requests wait on the valid/ready handshake until the matching window has passed. SRAM requests never depend on the flash line. All pulse widths and waits are parameters in clock cycles.

Top module: `dmem_bus_ctrl`

## Requirements
- R1: `fl_ce_n` and `sr_ce_n` are never low in the same cycle. In the cycle right after an accepted request, both are high.
- R2: In an access cycle only the selected memory's enable is low. A read drives that memory's output enable low with its write enable high and `bus_drive` low. A write drives its write enable low with its output enable high and `bus_drive` high.
- R3: After `supply_ok` rises, `fl_rst_n` first reads high at the (RST_LOW_CYC+1)-th falling clock edge, counting from the edge where the rise was applied.
- R4: While the bus is idle, `pd_req` high pulls `fl_rst_n` low at the next clock edge. The line then stays low while `pd_req` stays high, and for at least PD_LOW_CYC cycles in all. If `pd_req` is already low when that minimum runs out, release follows one cycle later.
- R5: After `fl_rst_n` goes high, a flash read is accepted only after RD_REC_CYC cycles (default 6). A flash write is accepted only after WR_REC_CYC cycles (default 3). No flash request is accepted while `fl_rst_n` is low or `pd_req` is high.
- R6: When `supply_ok` falls, `fl_rst_n` is low from the next clock edge, and flash requests are refused.
- R7: Host address bit 19 selects the memory: 0 selects the flash, 1 selects the SRAM. The flash receives bits 18:0 as its word address. The SRAM receives bits 17:0, and `mem_addr[18]` is 0. An SRAM write drives only the low data byte. An SRAM read returns its low byte with bits 15:8 as zero.
- R8: SRAM requests are accepted whatever the state of `fl_rst_n`, including during deep power-down and before the supply comes up.
- R9: A request accepted at a clock edge spends one setup cycle, then ACC_CYC cycles with its strobes low. A read returns the memory's data on a one-cycle `rsp_valid` pulse right after the access.
- R10: While `rst_n` is low, and before `supply_ok` rises, all enables are high, `fl_rst_n` is low and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ok | input | 1 | Flash supply within range |
| pd_req | input | 1 | Request deep power-down of the flash |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Bit 19 selects the memory; lower bits give the address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 16 | Read data |
| mem_addr | output | 19 | Shared memory address bus |
| bus_dout | output | 16 | Data driven to the memories |
| bus_drive | output | 1 | Controller drives the data bus |
| bus_din | input | 16 | Data returned by the memories |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_rst_n | output | 1 | Flash reset / deep power-down, active low |
| sr_ce_n | output | 1 | SRAM chip enable, active low |
| sr_oe_n | output | 1 | SRAM output enable, active low |
| sr_we_n | output | 1 | SRAM write enable, active low |

## Verification
The bench first sends SRAM writes and reads while the flash is still unpowered, which separates the SRAM path from the flash sequencer. It then sends back-to-back requests that alternate between the memories, which shows whether the idle setup cycle separates the two chip enables. It also uses an SRAM address with bit 18 set and a returned upper byte that is not zero, which exposes any leak of address or data bits. The recovery counts are measured once after a read request and once after a write request, so swapped or shared windows give different cycle counts. One power-down request is held longer than the minimum and another is dropped at once, which separates "held while requested" from "minimum hold".

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    typedef enum logic [1:0] {
        PS_OFF  = 2'd0,
        PS_HOLD = 2'd1,
        PS_WAKE = 2'd2,
        PS_DOWN = 2'd3
    } pwr_st_e;

    typedef enum logic [1:0] {
        BS_IDLE   = 2'd0,
        BS_SETUP  = 2'd1,
        BS_ACCESS = 2'd2
    } bus_st_e;

endpackage

// File: rtl/dmem_pwr_seq.sv
module dmem_pwr_seq
    import dmem_pkg::*;
#(
    parameter int RST_LOW_CYC = 10,
    parameter int PD_LOW_CYC  = 10,
    parameter int RD_REC_CYC  = 6,
    parameter int WR_REC_CYC  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic pd_req,
    input  logic bus_idle,
    output logic fl_rst_n,
    output logic rd_ok,
    output logic wr_ok
);

    localparam int REC_MAX = (RD_REC_CYC > WR_REC_CYC) ? RD_REC_CYC : WR_REC_CYC;
    localparam int LOW_MAX = (RST_LOW_CYC > PD_LOW_CYC) ? RST_LOW_CYC : PD_LOW_CYC;
    localparam int SEQ_MAX = (REC_MAX > LOW_MAX) ? REC_MAX : LOW_MAX;
    localparam int CNT_W   = $clog2(SEQ_MAX + 1) + 1;

    typedef struct packed {
        pwr_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic             rel;
        logic             rd_ok;
        logic             wr_ok;
    } seq_t;

    seq_t seq_q, seq_d;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            PS_OFF: begin
                if (supply_ok) begin
                    seq_d.st  = PS_HOLD;
                    seq_d.cnt = '0;
                end
            end
            PS_HOLD: begin
                if (seq_q.cnt == CNT_W'(RST_LOW_CYC - 1)) begin
                    seq_d.st  = PS_WAKE;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            PS_WAKE: begin
                if (pd_req && bus_idle) begin
                    seq_d.st  = PS_DOWN;
                    seq_d.cnt = '0;
                end else if (seq_q.cnt != CNT_W'(REC_MAX)) begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            PS_DOWN: begin
                if (seq_q.cnt == CNT_W'(PD_LOW_CYC - 1)) begin
                    if (!pd_req) begin
                        seq_d.st  = PS_WAKE;
                        seq_d.cnt = '0;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: begin
                seq_d.st  = PS_OFF;
                seq_d.cnt = '0;
            end
        endcase
        // losing the supply overrides every state
        if (!supply_ok) begin
            seq_d.st  = PS_OFF;
            seq_d.cnt = '0;
        end
        seq_d.rel   = (seq_d.st == PS_WAKE);
        seq_d.rd_ok = seq_d.rel && (seq_d.cnt >= CNT_W'(RD_REC_CYC));
        seq_d.wr_ok = seq_d.rel && (seq_d.cnt >= CNT_W'(WR_REC_CYC));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign fl_rst_n = seq_q.rel;
    assign rd_ok    = seq_q.rd_ok;
    assign wr_ok    = seq_q.wr_ok;

endmodule

// File: rtl/dmem_bus_fsm.sv
module dmem_bus_fsm
    import dmem_pkg::*;
#(
    parameter int FL_AW   = 19,
    parameter int SR_AW   = 18,
    parameter int DW      = 16,
    parameter int SR_DW   = 8,
    parameter int ACC_CYC = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [FL_AW:0]     req_addr,
    input  logic [DW-1:0]      req_wdata,
    input  logic               rd_ok,
    input  logic               wr_ok,
    input  logic               pd_req,
    output logic               bus_idle,
    output logic               rsp_valid,
    output logic [DW-1:0]      rsp_rdata,
    output logic [FL_AW-1:0]   mem_addr,
    output logic [DW-1:0]      bus_dout,
    output logic               bus_drive,
    input  logic [DW-1:0]      bus_din,
    output logic               fl_ce_n,
    output logic               fl_oe_n,
    output logic               fl_we_n,
    output logic               sr_ce_n,
    output logic               sr_oe_n,
    output logic               sr_we_n
);

    localparam int ACW = $clog2(ACC_CYC + 1);

    typedef struct packed {
        bus_st_e          st;
        logic [ACW-1:0]   cnt;
        logic             is_sr;
        logic             is_wr;
        logic [FL_AW-1:0] addr;
        logic [DW-1:0]    wdata;
        logic [DW-1:0]    rdata;
        logic             rsp;
        logic             drive;
        logic             fce;
        logic             foe;
        logic             fwe;
        logic             sce;
        logic             soe;
        logic             swe;
    } bus_t;

    bus_t bus_q, bus_d;
    logic req_sr;
    logic fl_ok;
    logic act;

    always_comb begin
        req_sr    = req_addr[FL_AW];
        fl_ok     = !pd_req && (req_write ? wr_ok : rd_ok);
        req_ready = (bus_q.st == BS_IDLE) && (req_sr || fl_ok);

        bus_d     = bus_q;
        bus_d.rsp = 1'b0;
        case (bus_q.st)
            BS_IDLE: begin
                if (req_valid && req_ready) begin
                    bus_d.st    = BS_SETUP;
                    bus_d.is_sr = req_sr;
                    bus_d.is_wr = req_write;
                    bus_d.addr  = req_sr ? {{(FL_AW-SR_AW){1'b0}}, req_addr[SR_AW-1:0]}
                                         : req_addr[FL_AW-1:0];
                    bus_d.wdata = req_sr ? {{(DW-SR_DW){1'b0}}, req_wdata[SR_DW-1:0]}
                                         : req_wdata;
                end
            end
            BS_SETUP: begin
                bus_d.st  = BS_ACCESS;
                bus_d.cnt = '0;
            end
            BS_ACCESS: begin
                if (bus_q.cnt == ACW'(ACC_CYC - 1)) begin
                    bus_d.st = BS_IDLE;
                    if (!bus_q.is_wr) begin
                        bus_d.rsp   = 1'b1;
                        bus_d.rdata = bus_q.is_sr ? {{(DW-SR_DW){1'b0}}, bus_din[SR_DW-1:0]}
                                                  : bus_din;
                    end
                end else begin
                    bus_d.cnt = bus_q.cnt + 1'b1;
                end
            end
            default: bus_d.st = BS_IDLE;
        endcase

        // strobes are registered copies of the next state decode
        act         = (bus_d.st == BS_ACCESS);
        bus_d.fce   = act && !bus_d.is_sr;
        bus_d.sce   = act && bus_d.is_sr;
        bus_d.foe   = bus_d.fce && !bus_d.is_wr;
        bus_d.fwe   = bus_d.fce && bus_d.is_wr;
        bus_d.soe   = bus_d.sce && !bus_d.is_wr;
        bus_d.swe   = bus_d.sce && bus_d.is_wr;
        bus_d.drive = bus_d.is_wr && (bus_d.st != BS_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q <= '0;
        end else begin
            bus_q <= bus_d;
        end
    end

    assign bus_idle  = (bus_q.st == BS_IDLE);
    assign rsp_valid = bus_q.rsp;
    assign rsp_rdata = bus_q.rdata;
    assign mem_addr  = bus_q.addr;
    assign bus_dout  = bus_q.wdata;
    assign bus_drive = bus_q.drive;
    assign fl_ce_n   = !bus_q.fce;
    assign fl_oe_n   = !bus_q.foe;
    assign fl_we_n   = !bus_q.fwe;
    assign sr_ce_n   = !bus_q.sce;
    assign sr_oe_n   = !bus_q.soe;
    assign sr_we_n   = !bus_q.swe;

endmodule

// File: rtl/dmem_bus_ctrl.sv
module dmem_bus_ctrl #(
    parameter int FL_AW       = 19,
    parameter int SR_AW       = 18,
    parameter int DW          = 16,
    parameter int SR_DW       = 8,
    parameter int ACC_CYC     = 12,
    parameter int RST_LOW_CYC = 10,
    parameter int PD_LOW_CYC  = 10,
    parameter int RD_REC_CYC  = 6,
    parameter int WR_REC_CYC  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic             pd_req,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [FL_AW:0]   req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata,
    output logic [FL_AW-1:0] mem_addr,
    output logic [DW-1:0]    bus_dout,
    output logic             bus_drive,
    input  logic [DW-1:0]    bus_din,
    output logic             fl_ce_n,
    output logic             fl_oe_n,
    output logic             fl_we_n,
    output logic             fl_rst_n,
    output logic             sr_ce_n,
    output logic             sr_oe_n,
    output logic             sr_we_n
);

    localparam int HOST_AW = FL_AW + 1;
    localparam int MIN_LOW = (RST_LOW_CYC < PD_LOW_CYC) ? RST_LOW_CYC : PD_LOW_CYC;

    logic rd_ok;
    logic wr_ok;
    logic bus_idle;

    dmem_pwr_seq #(
        .RST_LOW_CYC(RST_LOW_CYC),
        .PD_LOW_CYC (PD_LOW_CYC),
        .RD_REC_CYC (RD_REC_CYC),
        .WR_REC_CYC (WR_REC_CYC)
    ) u_pwr_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .supply_ok(supply_ok),
        .pd_req   (pd_req),
        .bus_idle (bus_idle),
        .fl_rst_n (fl_rst_n),
        .rd_ok    (rd_ok),
        .wr_ok    (wr_ok)
    );

    dmem_bus_fsm #(
        .FL_AW  (FL_AW),
        .SR_AW  (SR_AW),
        .DW     (DW),
        .SR_DW  (SR_DW),
        .ACC_CYC(ACC_CYC)
    ) u_bus_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .rd_ok    (rd_ok),
        .wr_ok    (wr_ok),
        .pd_req   (pd_req),
        .bus_idle (bus_idle),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata),
        .mem_addr (mem_addr),
        .bus_dout (bus_dout),
        .bus_drive(bus_drive),
        .bus_din  (bus_din),
        .fl_ce_n  (fl_ce_n),
        .fl_oe_n  (fl_oe_n),
        .fl_we_n  (fl_we_n),
        .sr_ce_n  (sr_ce_n),
        .sr_oe_n  (sr_oe_n),
        .sr_we_n  (sr_we_n)
    );

endmodule

// File: rtl/dmem_bus_ctrl_chk.sv
module dmem_bus_ctrl_chk #(
    parameter int MIN_LOW = 10
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic acc_fl,
    input logic rsp_valid,
    input logic bus_drive,
    input logic fl_ce_n,
    input logic fl_oe_n,
    input logic fl_we_n,
    input logic fl_rst_n,
    input logic sr_ce_n,
    input logic sr_oe_n,
    input logic sr_we_n
);

    localparam int LW = $clog2(MIN_LOW + 2) + 1;

    // consecutive cycles the flash reset line has been low
    logic [LW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (fl_rst_n) begin
            low_run <= '0;
        end else if (low_run != {LW{1'b1}}) begin
            low_run <= low_run + 1'b1;
        end
    end

    AST_CE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_ce_n && !sr_ce_n)); // R1
    AST_FL_AFTER_SR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_ce_n |-> $past(sr_ce_n)); // R1
    AST_SR_AFTER_FL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_ce_n |-> $past(fl_ce_n)); // R1
    AST_FL_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_oe_n && !fl_we_n)); // R2
    AST_SR_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sr_oe_n && !sr_we_n)); // R2
    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n || !sr_we_n) |-> bus_drive); // R2
    AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_oe_n || !sr_oe_n) |-> !bus_drive); // R2
    AST_RST_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_rst_n) |-> (low_run >= LW'(MIN_LOW))); // R3
    AST_FL_ACCEPT_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fl |-> fl_rst_n); // R5
    AST_SUPPLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !fl_rst_n); // R6
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R9

endmodule

bind dmem_bus_ctrl dmem_bus_ctrl_chk #(
    .MIN_LOW(MIN_LOW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .supply_ok(supply_ok),
    .acc_fl   (req_valid && req_ready && !req_addr[HOST_AW-1]),
    .rsp_valid(rsp_valid),
    .bus_drive(bus_drive),
    .fl_ce_n  (fl_ce_n),
    .fl_oe_n  (fl_oe_n),
    .fl_we_n  (fl_we_n),
    .fl_rst_n (fl_rst_n),
    .sr_ce_n  (sr_ce_n),
    .sr_oe_n  (sr_oe_n),
    .sr_we_n  (sr_we_n)
);

// File: tb/dmem_bus_ctrl_bench.sv
module dmem_bus_ctrl_bench;

    localparam int ACC  = 12;
    localparam int RSTL = 10;
    localparam int PDL  = 10;
    localparam int RDR  = 6;
    localparam int WRR  = 3;

    logic        clk = 1'b0;
    logic        rst_n, supply_ok, pd_req;
    logic        req_valid, req_ready, req_write;
    logic [19:0] req_addr;
    logic [15:0] req_wdata;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [18:0] mem_addr;
    logic [15:0] bus_dout, bus_din;
    logic        bus_drive;
    logic        fl_ce_n, fl_oe_n, fl_we_n, fl_rst_n, sr_ce_n, sr_oe_n, sr_we_n;

    always #5 clk = ~clk;

    dmem_bus_ctrl #(
        .ACC_CYC(ACC), .RST_LOW_CYC(RSTL), .PD_LOW_CYC(PDL),
        .RD_REC_CYC(RDR), .WR_REC_CYC(WRR)
    ) u_dmem_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pd_req(pd_req),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .bus_dout(bus_dout), .bus_drive(bus_drive),
        .bus_din(bus_din),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_rst_n(fl_rst_n),
        .sr_ce_n(sr_ce_n), .sr_oe_n(sr_oe_n), .sr_we_n(sr_we_n)
    );

    // small memory models; the SRAM returns a non-zero upper byte on purpose
    logic [15:0] fl_mem [0:63];
    logic [7:0]  sr_mem [0:63];

    always_comb begin
        bus_din = 16'h0000;
        if (!fl_ce_n && !fl_oe_n)      bus_din = fl_mem[mem_addr[5:0]];
        else if (!sr_ce_n && !sr_oe_n) bus_din = {8'hA5, sr_mem[mem_addr[5:0]]};
    end

    always @(posedge fl_we_n) if (rst_n === 1'b1) fl_mem[mem_addr[5:0]] <= bus_dout;
    always @(posedge sr_we_n) if (rst_n === 1'b1) sr_mem[mem_addr[5:0]] <= bus_dout[7:0];

    int n_chk  = 0;
    int n_fail = 0;
    int n;
    logic [15:0] exp_q [$];
    string       tag_q [$];
    logic [15:0] e_val;
    string       e_tag;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n === 1'b1 && rsp_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected response", {16'h0, rsp_rdata}, 32'h0);
            end else begin
                e_val = exp_q.pop_front();
                e_tag = tag_q.pop_front();
                check(rsp_rdata === e_val, e_tag, {16'h0, rsp_rdata}, {16'h0, e_val});
            end
        end
    end

    // driver: one complete request, called at a falling edge
    task automatic xfer(input bit wr, input logic [19:0] a, input logic [15:0] wd,
                        input logic [15:0] exp, input string tag);
        logic [18:0] exp_addr;
        int cnt;
        req_write = wr; req_addr = a; req_wdata = wd; req_valid = 1'b1;
        #1;
        while (!req_ready) begin
            @(negedge clk); #1;
        end
        if (!wr) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(fl_ce_n && sr_ce_n, "R1 setup cycle keeps both enables high",
              {30'h0, fl_ce_n, sr_ce_n}, 32'h3);
        @(negedge clk);
        exp_addr = a[19] ? {1'b0, a[17:0]} : a[18:0];
        check(mem_addr === exp_addr, "R7 address routed to memory", mem_addr, exp_addr);
        if (a[19])
            check(!sr_ce_n && fl_ce_n && sr_oe_n == wr && sr_we_n == !wr && bus_drive == wr,
                  "R2 SRAM strobes", {sr_ce_n, sr_oe_n, sr_we_n, fl_ce_n, bus_drive},
                  {1'b0, wr, !wr, 1'b1, wr});
        else
            check(!fl_ce_n && sr_ce_n && fl_oe_n == wr && fl_we_n == !wr && bus_drive == wr,
                  "R2 flash strobes", {fl_ce_n, fl_oe_n, fl_we_n, sr_ce_n, bus_drive},
                  {1'b0, wr, !wr, 1'b1, wr});
        cnt = 0;
        while ((a[19] ? sr_ce_n : fl_ce_n) == 1'b0) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == ACC, "R9 access length", cnt, ACC);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            fl_mem[i] = 16'h1000 + 16'(i);
            sr_mem[i] = 8'h00;
        end
        rst_n = 1'b0; supply_ok = 1'b0; pd_req = 1'b0;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        check(fl_ce_n && sr_ce_n && fl_oe_n && fl_we_n && sr_oe_n && sr_we_n,
              "R10 enables high in reset", {fl_ce_n, sr_ce_n}, 2'b11);
        rst_n = 1'b1;
        @(negedge clk);
        check(!fl_rst_n, "R10 flash reset low before supply", fl_rst_n, 0);
        check(!rsp_valid, "R10 no response after reset", rsp_valid, 0);

        // flash refused, SRAM accepted while the flash is unpowered
        req_addr = 20'h00003; req_write = 1'b0; req_valid = 1'b1; #1;
        check(!req_ready, "R6 flash refused without supply", req_ready, 0);
        req_addr = 20'h80003; #1;
        check(req_ready, "R8 SRAM accepted without supply", req_ready, 1);
        req_valid = 1'b0;
        @(negedge clk);
        xfer(1'b1, 20'hC0007, 16'h1234, 16'h0, "R7 SRAM write");
        xfer(1'b0, 20'h80007, 16'h0, 16'h0034, "R7 SRAM read low byte, upper zero");

        // power-up hold
        supply_ok = 1'b1;
        n = 0;
        while (!fl_rst_n) begin @(negedge clk); n++; end
        check(n == RSTL + 1, "R3 reset hold after supply good", n, RSTL + 1);

        // read recovery
        req_addr = 20'h00003; req_write = 1'b0; req_valid = 1'b1; #1;
        n = 0;
        while (!req_ready) begin @(negedge clk); #1; n++; end
        check(n == RDR, "R5 read recovery window", n, RDR);
        xfer(1'b0, 20'h00003, 16'h0, 16'h1003, "R9 flash read data");

        xfer(1'b1, 20'h00005, 16'hBEEF, 16'h0, "R9 flash write");
        xfer(1'b0, 20'h00005, 16'h0, 16'hBEEF, "R9 flash read back");
        xfer(1'b0, 20'h80007, 16'h0, 16'h0034, "R1 alternate to SRAM");
        xfer(1'b0, 20'h00003, 16'h0, 16'h1003, "R1 alternate to flash");

        // long deep power-down with SRAM traffic inside
        @(negedge clk);
        pd_req = 1'b1;
        @(negedge clk);
        check(!fl_rst_n, "R4 power-down entry", fl_rst_n, 0);
        req_addr = 20'h00003; req_write = 1'b0; req_valid = 1'b1; #1;
        check(!req_ready, "R5 flash refused while powered down", req_ready, 0);
        req_valid = 1'b0;
        xfer(1'b0, 20'hC0007, 16'h0, 16'h0034, "R8 SRAM read during power-down");
        check(!fl_rst_n, "R4 held while requested", fl_rst_n, 0);
        pd_req = 1'b0;
        n = 0;
        while (!fl_rst_n) begin @(negedge clk); n++; end
        check(n == 1, "R4 release after long request", n, 1);

        // short request: minimum hold governs
        @(negedge clk);
        pd_req = 1'b1;
        @(negedge clk);
        pd_req = 1'b0;
        n = 0;
        while (!fl_rst_n) begin n++; @(negedge clk); end
        check(n == PDL, "R4 minimum power-down hold", n, PDL);

        // write recovery
        req_addr = 20'h00009; req_write = 1'b1; req_wdata = 16'hC0DE; req_valid = 1'b1; #1;
        n = 0;
        while (!req_ready) begin @(negedge clk); #1; n++; end
        check(n == WRR, "R5 write recovery window", n, WRR);
        xfer(1'b1, 20'h00009, 16'hC0DE, 16'h0, "R9 flash write after wake");
        xfer(1'b0, 20'h00009, 16'h0, 16'hC0DE, "R9 flash read after wake");

        // supply loss
        @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        check(!fl_rst_n, "R6 reset low after supply loss", fl_rst_n, 0);
        req_addr = 20'h00001; req_write = 1'b1; req_valid = 1'b1; #1;
        check(!req_ready, "R6 flash refused after supply loss", req_ready, 0);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule